// File: doc/BRIEF.md
# Frame-Locked Internal Bit Clock Generator

This block runs on the master clock of an audio serial port and produces the serial bit clock when that clock is generated on chip. From a speed-mode code and a code for the master-clock multiple of the frame rate, it picks how many bit clocks fit in one frame (32, 48 or 64). It then divides the master-clock multiple by that count to get the number of master-clock cycles per bit, and toggles the bit clock with an equal low and high half inside each bit period.

The divider is not free-running. Each change of level on the left/right frame clock restarts the bit period in its low half, so bit-clock edges always line up with the frame boundaries. Combinations of speed mode and master-clock multiple that have no legal bit ratio raise an unsupported flag, and the bit clock is then held low. The bit clock is also held low while the enable is deasserted. The block does not shift data and does not decide when internal clocking is in use.

Top module: `isck_gen`

## Requirements
- R1: In single speed (speed code 0), the bit-clock count per frame is 64 for master-clock codes 2, 4, 5 and 6 (256x, 512x, 768x, 1024x).
- R2: In single speed, master-clock code 3 (384x) gives 48 bit clocks per frame.
- R3: In double speed (speed code 1), only master-clock code 1 (192x) is supported and gives 48 bit clocks per frame. Every other code is flagged unsupported.
- R4: In quad speed (speed code 2), master-clock codes 0 (128x) and 1 (192x) give 32 bit clocks per frame.
- R5: The reported divide factor equals the master-clock multiple divided by the bit count. Master-clock codes 0 to 6 stand for 128x, 192x, 256x, 384x, 512x, 768x and 1024x, so for example 384/48 = 8 and 1024/64 = 16.
- R6: Any other combination raises the unsupported flag and reports a bit count and a divide factor of zero. This covers speed code 3, master-clock code 7, single speed with 128x or 192x, and quad speed above 192x.
- R7: One cycle after the unsupported flag is seen high, the bit clock is low, and it stays low while the flag stays high.
- R8: One cycle after the enable is seen low, the bit clock is low, and it stays low while the enable stays low.
- R9: While enabled and supported, with no frame-clock change, the bit clock is low for div/2 master cycles and then high for div/2, so its period is div.
- R10: When a change of the frame-clock level is sampled, the bit period restarts. The bit clock is low for the following div/2 cycles and rises on the next one.
- R11: During reset the bit clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables bit-clock generation |
| speed_i | input | 2 | Speed mode: 0 single, 1 double, 2 quad, 3 reserved |
| mclk_sel_i | input | 3 | Master-clock multiple code, 0..6 = 128x..1024x, 7 reserved |
| lrck_i | input | 1 | Left/right frame clock, synchronous to clk_i |
| sck_o | output | 1 | Generated bit clock |
| unsup_o | output | 1 | High for an unsupported mode combination |
| bits_o | output | RATIO_W | Bit clocks per frame (0 when unsupported) |
| div_o | output | DIV_W | Master cycles per bit clock (0 when unsupported) |

## Verification
The checker watches every cycle for three things. The bit clock must fall silent one cycle after a disable, an unsupported mode or a sampled frame-clock change. A supported mode must report a legal bit count together with an even divide factor of at least four. The clock may only rise after a cycle in which the block was running. Only the bench's scenarios can show the exact table values per mode, the half-period lengths and the total high time over a frame, and the cycle on which the clock rises again after an early frame edge. The bench's behavioural model follows these across mode changes cycle by cycle.

// File: rtl/isck_pkg.sv
`timescale 1ns/1ps
package isck_pkg;

   typedef enum logic [1:0] {
      SPD_SINGLE = 2'd0,
      SPD_DOUBLE = 2'd1,
      SPD_QUAD   = 2'd2,
      SPD_RSVD   = 2'd3
   } speed_e;

   // master clock multiple codes: bit 0 picks the 128/192 base, bits 2:1 shift it
   localparam logic [2:0] MC_128X  = 3'd0;
   localparam logic [2:0] MC_192X  = 3'd1;
   localparam logic [2:0] MC_256X  = 3'd2;
   localparam logic [2:0] MC_384X  = 3'd3;
   localparam logic [2:0] MC_512X  = 3'd4;
   localparam logic [2:0] MC_768X  = 3'd5;
   localparam logic [2:0] MC_1024X = 3'd6;

   localparam int BASE_EVEN = 128;
   localparam int BASE_ODD  = 192;

   localparam int BITS_32 = 32;
   localparam int BITS_48 = 48;
   localparam int BITS_64 = 64;

endpackage

// File: rtl/isck_ratio_sel.sv
`timescale 1ns/1ps
module isck_ratio_sel
   import isck_pkg::*;
#(
   parameter int MULT_W  = 11,
   parameter int RATIO_W = 7
) (
   input  logic [1:0]         speed_i,
   input  logic [2:0]         mclk_sel_i,
   output logic [MULT_W-1:0]  mult_o,
   output logic [RATIO_W-1:0] bits_o,
   output logic               unsup_o
);

   logic [MULT_W-1:0] base;

   assign base   = mclk_sel_i[0] ? MULT_W'(BASE_ODD) : MULT_W'(BASE_EVEN);
   assign mult_o = base << mclk_sel_i[2:1];

   always_comb begin
      bits_o = '0;
      case (speed_e'(speed_i))
         SPD_SINGLE: begin
            if (mclk_sel_i == MC_384X) begin
               bits_o = RATIO_W'(BITS_48);
            end else if (mclk_sel_i inside {MC_256X, MC_512X, MC_768X, MC_1024X}) begin
               bits_o = RATIO_W'(BITS_64);
            end
         end
         SPD_DOUBLE: begin
            if (mclk_sel_i == MC_192X) begin
               bits_o = RATIO_W'(BITS_48);
            end
         end
         SPD_QUAD: begin
            if (mclk_sel_i inside {MC_128X, MC_192X}) begin
               bits_o = RATIO_W'(BITS_32);
            end
         end
         default: bits_o = '0;
      endcase
      unsup_o = (bits_o == '0);
   end

endmodule

// File: rtl/isck_div_calc.sv
`timescale 1ns/1ps
module isck_div_calc #(
   parameter int MULT_W  = 11,
   parameter int RATIO_W = 7,
   parameter int DIV_W   = 5
) (
   input  logic [MULT_W-1:0]  dividend_i,
   input  logic [RATIO_W-1:0] divisor_i,
   output logic [DIV_W-1:0]   quot_o,
   output logic               ovf_o,
   output logic               exact_o
);

   logic [MULT_W-1:0]  q;
   logic [RATIO_W-1:0] rem_s [MULT_W+1];

   assign rem_s[0] = '0;

   // restoring division, one stage per dividend bit, MSB first
   for (genvar i = 0; i < MULT_W; i++) begin : g_stage
      localparam int B = MULT_W - 1 - i;
      logic [RATIO_W:0]   shl;
      logic [RATIO_W-1:0] diff;
      logic               ge;

      assign shl          = {rem_s[i], dividend_i[B]};
      assign ge           = (shl >= {1'b0, divisor_i});
      assign diff         = shl[RATIO_W-1:0] - divisor_i;
      assign q[B]         = ge;
      assign rem_s[i+1]   = ge ? diff : shl[RATIO_W-1:0];
   end

   assign quot_o  = q[DIV_W-1:0];
   assign ovf_o   = |q[MULT_W-1:DIV_W];
   assign exact_o = (rem_s[MULT_W] == '0);

endmodule

// File: rtl/isck_frame_edge.sv
`timescale 1ns/1ps
module isck_frame_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lrck_i,
   output logic edge_o
);

   logic lrck_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lrck_q <= 1'b0;
      end else begin
         lrck_q <= lrck_i;
      end
   end

   assign edge_o = lrck_i ^ lrck_q;

endmodule

// File: rtl/isck_divider.sv
`timescale 1ns/1ps
module isck_divider #(
   parameter int DIV_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             restart_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             sck_o
);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] cnt_nx;
   logic [DIV_W-1:0] half;
   logic [DIV_W-1:0] last;

   assign half = div_i >> 1;
   assign last = div_i - DIV_W'(1);

   always_comb begin
      if (!run_i || restart_i) begin
         cnt_nx = '0;
      end else if (cnt_q >= last) begin
         cnt_nx = '0;
      end else begin
         cnt_nx = cnt_q + DIV_W'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         sck_o <= 1'b0;
      end else begin
         cnt_q <= cnt_nx;
         sck_o <= run_i && (cnt_nx >= half);
      end
   end

endmodule

// File: rtl/isck_gen.sv
`timescale 1ns/1ps
module isck_gen #(
   parameter int MULT_W   = 11,
   parameter int RATIO_W  = 7,
   parameter int DIV_W    = 5,
   parameter int CFG_PIPE = 0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_i,
   input  logic [1:0]         speed_i,
   input  logic [2:0]         mclk_sel_i,
   input  logic               lrck_i,
   output logic               sck_o,
   output logic               unsup_o,
   output logic [RATIO_W-1:0] bits_o,
   output logic [DIV_W-1:0]   div_o
);

   // elaboration-time parameter checks
   if (MULT_W < 11) begin : g_bad_mult
      $error("MULT_W must hold a 1024x multiple");
   end
   if (RATIO_W < 7) begin : g_bad_ratio
      $error("RATIO_W must hold a ratio of 64");
   end
   if (DIV_W < 5 || DIV_W >= MULT_W) begin : g_bad_div
      $error("DIV_W must hold 16 and stay below MULT_W");
   end
   if (CFG_PIPE != 0 && CFG_PIPE != 1) begin : g_bad_pipe
      $error("CFG_PIPE must be 0 or 1");
   end

   logic [MULT_W-1:0]  mult;
   logic [RATIO_W-1:0] bits_raw;
   logic               sel_unsup;
   logic [DIV_W-1:0]   quot;
   logic               ovf;
   logic               exact;
   logic               bad;
   logic [RATIO_W-1:0] cfg_bits;
   logic [DIV_W-1:0]   cfg_div;
   logic               frame_edge;
   logic               run;

   isck_ratio_sel #(
      .MULT_W (MULT_W),
      .RATIO_W(RATIO_W)
   ) u_sel (
      .speed_i   (speed_i),
      .mclk_sel_i(mclk_sel_i),
      .mult_o    (mult),
      .bits_o    (bits_raw),
      .unsup_o   (sel_unsup)
   );

   isck_div_calc #(
      .MULT_W (MULT_W),
      .RATIO_W(RATIO_W),
      .DIV_W  (DIV_W)
   ) u_calc (
      .dividend_i(mult),
      .divisor_i (bits_raw),
      .quot_o    (quot),
      .ovf_o     (ovf),
      .exact_o   (exact)
   );

   assign bad      = sel_unsup | ovf | ~exact;
   assign cfg_bits = bad ? '0 : bits_raw;
   assign cfg_div  = bad ? '0 : quot;

   if (CFG_PIPE == 1) begin : g_pipe
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            unsup_o <= 1'b1;
            bits_o  <= '0;
            div_o   <= '0;
         end else begin
            unsup_o <= bad;
            bits_o  <= cfg_bits;
            div_o   <= cfg_div;
         end
      end
   end else begin : g_comb
      assign unsup_o = bad;
      assign bits_o  = cfg_bits;
      assign div_o   = cfg_div;
   end

   isck_frame_edge u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lrck_i(lrck_i),
      .edge_o(frame_edge)
   );

   assign run = en_i & ~unsup_o;

   isck_divider #(
      .DIV_W(DIV_W)
   ) u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run),
      .restart_i(frame_edge),
      .div_i    (div_o),
      .sck_o    (sck_o)
   );

endmodule

// File: rtl/isck_gen_chk.sv
`timescale 1ns/1ps
module isck_gen_chk #(
   parameter int RATIO_W = 7,
   parameter int DIV_W   = 5
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               en_i,
   input logic               lrck_i,
   input logic               sck_o,
   input logic               unsup_o,
   input logic [RATIO_W-1:0] bits_o,
   input logic [DIV_W-1:0]   div_o
);

   logic lr_seen;
   logic edge_c;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lr_seen <= 1'b0;
      end else begin
         lr_seen <= lrck_i;
      end
   end

   assign edge_c = (lrck_i != lr_seen);

   a_r8_low_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !sck_o) else $error("R8 bit clock high after disable");

   a_r7_low_when_unsup: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unsup_o |=> !sck_o) else $error("R7 bit clock high in unsupported mode");

   a_r10_restart_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !unsup_o && edge_c) |=> !sck_o) else $error("R10 bit clock not low after frame edge");

   a_r6_unsup_zero_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unsup_o |-> (bits_o == '0 && div_o == '0)) else $error("R6 nonzero config when unsupported");

   a_r5_div_even_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !unsup_o |-> (!div_o[0] && div_o >= DIV_W'(4))) else $error("R5 divide factor illegal");

   a_r1_ratio_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !unsup_o |-> (bits_o == RATIO_W'(32) || bits_o == RATIO_W'(48) || bits_o == RATIO_W'(64)))
      else $error("R1 bit count outside 32/48/64");

   a_r9_rise_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sck_o) |-> ($past(en_i) && !$past(unsup_o))) else $error("R9 rise without running");

endmodule

bind isck_gen isck_gen_chk #(
   .RATIO_W(RATIO_W),
   .DIV_W  (DIV_W)
) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .en_i   (en_i),
   .lrck_i (lrck_i),
   .sck_o  (sck_o),
   .unsup_o(unsup_o),
   .bits_o (bits_o),
   .div_o  (div_o)
);

// File: tb/sim_isck_gen.sv
`timescale 1ns/1ps
module sim_isck_gen;

   localparam int RW = 7;
   localparam int DW = 5;

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic          en    = 1'b0;
   logic          lrck  = 1'b0;
   logic [1:0]    spd   = 2'd0;
   logic [2:0]    sel   = 3'd2;
   logic          sck;
   logic          unsup;
   logic [RW-1:0] bits;
   logic [DW-1:0] dv;

   always #4 clk = ~clk;

   isck_gen u0 (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .en_i      (en),
      .speed_i   (spd),
      .mclk_sel_i(sel),
      .lrck_i    (lrck),
      .sck_o     (sck),
      .unsup_o   (unsup),
      .bits_o    (bits),
      .div_o     (dv)
   );

   int    checks = 0;
   int    errors = 0;
   string tag    = "R11";
   int    lr_half = 128;
   bit    lr_run  = 1'b0;
   int    lc      = 0;
   int    cyc     = 0;

   // behavioural reference
   int m_prev = 0;
   int m_ph   = 0;
   int m_sck  = 0;

   function automatic int ref_mult(int s);
      case (s)
         0: return 128;
         1: return 192;
         2: return 256;
         3: return 384;
         4: return 512;
         5: return 768;
         6: return 1024;
         default: return 0;
      endcase
   endfunction

   function automatic int ref_bits(int sp, int s);
      int m;
      m = ref_mult(s);
      if (sp == 0 && m == 384) return 48;
      if (sp == 0 && (m == 256 || m == 512 || m == 768 || m == 1024)) return 64;
      if (sp == 1 && m == 192) return 48;
      if (sp == 2 && (m == 128 || m == 192)) return 32;
      return 0;
   endfunction

   function automatic int ref_div(int sp, int s);
      int b;
      b = ref_bits(sp, s);
      if (b == 0) return 0;
      return ref_mult(s) / b;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_prev = 0;
         m_ph   = 0;
         m_sck  = 0;
      end else begin
         int d;
         bit e;
         d = ref_div(int'(spd), int'(sel));
         e = (int'(lrck) != m_prev);
         m_prev = int'(lrck);
         if (!en || d == 0) begin
            m_ph  = 0;
            m_sck = 0;
         end else begin
            if (e) m_ph = 0;
            else if (m_ph + 1 >= d) m_ph = 0;
            else m_ph = m_ph + 1;
            m_sck = (m_ph >= d / 2) ? 1 : 0;
         end
      end
   end

   task automatic check_val(string t, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      check_val(tag, "sck_o", int'(sck), m_sck);
      check_val(tag, "unsup_o", int'(unsup), (ref_bits(int'(spd), int'(sel)) == 0) ? 1 : 0);
      check_val(tag, "bits_o", int'(bits), ref_bits(int'(spd), int'(sel)));
      check_val(tag, "div_o", int'(dv), ref_div(int'(spd), int'(sel)));
      if (lr_run) begin
         lc++;
         if (lc >= lr_half) begin
            lrck = ~lrck;
            lc   = 0;
         end
      end
   endtask

   task automatic cfg_check(int sp, int s, int eb, int ed, int eu, string t);
      spd = 2'(sp);
      sel = 3'(s);
      tag = t;
      tick();
      check_val(t, "bits_o table", int'(bits), eb);
      check_val("R5", "div_o table", int'(dv), ed);
      check_val("R6", "unsup_o table", int'(unsup), eu);
   endtask

   task automatic run_mode(int sp, int s, int half, int n, string t);
      spd     = 2'(sp);
      sel     = 3'(s);
      en      = 1'b1;
      lr_half = half;
      lr_run  = 1'b1;
      tag     = t;
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic count_high(int n, output int ones);
      ones = 0;
      for (int i = 0; i < n; i++) begin
         tick();
         ones += int'(sck);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int ones;

      // R11: reset holds the bit clock low
      tag = "R11";
      for (int i = 0; i < 3; i++) begin
         tick();
         check_val("R11", "sck_o in reset", int'(sck), 0);
      end
      rst_n = 1'b1;
      tick();

      // decode table, enable low
      cfg_check(0, 2, 64, 4, 0, "R1");
      cfg_check(0, 4, 64, 8, 0, "R1");
      cfg_check(0, 5, 64, 12, 0, "R1");
      cfg_check(0, 6, 64, 16, 0, "R1");
      cfg_check(0, 3, 48, 8, 0, "R2");
      cfg_check(1, 1, 48, 4, 0, "R3");
      cfg_check(1, 2, 0, 0, 1, "R3");
      cfg_check(2, 0, 32, 4, 0, "R4");
      cfg_check(2, 1, 32, 6, 0, "R4");
      cfg_check(2, 3, 0, 0, 1, "R6");
      cfg_check(0, 0, 0, 0, 1, "R6");
      cfg_check(0, 1, 0, 0, 1, "R6");
      cfg_check(3, 2, 0, 0, 1, "R6");
      cfg_check(0, 7, 0, 0, 1, "R6");

      // R9: steady running, duty checked over whole frames
      run_mode(0, 2, 128, 300, "R9");
      count_high(256, ones);
      check_val("R9", "high cycles 256x", ones, 128);
      run_mode(0, 3, 192, 400, "R9");
      count_high(384, ones);
      check_val("R9", "high cycles 384x", ones, 192);
      run_mode(2, 1, 96, 200, "R9");
      count_high(192, ones);
      check_val("R9", "high cycles quad 192x", ones, 96);
      run_mode(1, 1, 96, 200, "R3");
      run_mode(2, 0, 64, 200, "R4");

      // R10: early frame edge restarts the bit period (div 16)
      run_mode(0, 6, 512, 605, "R10");
      lrck = ~lrck;
      lc   = 0;
      for (int k = 1; k <= 9; k++) begin
         tick();
         if (k == 1 || k == 8) check_val("R10", "sck_o low after edge", int'(sck), 0);
         if (k == 9) check_val("R10", "sck_o rises after half", int'(sck), 1);
      end
      run_mode(0, 6, 512, 200, "R10");

      // R8: disable holds low
      tag = "R8";
      en  = 1'b0;
      tick();
      check_val("R8", "sck_o after disable", int'(sck), 0);
      count_high(40, ones);
      check_val("R8", "high cycles disabled", ones, 0);

      // R7: unsupported mode while enabled holds low
      run_mode(0, 2, 128, 100, "R7");
      sel = 3'd0;
      tick();
      check_val("R7", "unsup_o", int'(unsup), 1);
      count_high(40, ones);
      check_val("R7", "high cycles unsupported", ones, 0);
      run_mode(0, 2, 128, 100, "R9");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule